// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen-Copy Readout

This block keeps calendar time in binary-coded decimal: seconds, minutes, hours, day of month, day of week, month, two-digit year and century. A once-per-second pulse advances a set of internal counters. One cycle later the new time is copied into a separate bank of user-visible registers. Software reaches every register through a byte-wide bus, using a flat offset from the block's base; there is no index/data indirection.

To read a consistent snapshot, software sets the freeze bit. The user bank then stops refreshing while the internal counters keep running. To set the clock, software freezes the bank, writes new field values, then clears the freeze bit; that write commits the written bank into the counters. An alarm compares four match fields (second, minute, hour, day of month) against the new time at each tick. A match sets a flag that a bus read of the flags register clears. The interrupt output follows the flag when the interrupt enable is on.

Every bus access finishes in the cycle it is presented. The bus therefore carries no valid/ready pair and never applies back-pressure. A read returns data combinationally in the same cycle. A write takes effect at the next clock edge.

Top module: `bcd_rtc`

## Requirements
- R1: All eight time fields hold valid BCD. After reset the clock reads 2000-01-01 00:00:00 with day of week 01, and the control register reads 0x05.
- R2: A tick with the run bit set advances the counters by one second. When the freeze bit is 0, the user registers show the new time from the cycle after the tick.
- R3: While control bit 3 (freeze) is 1, the user-visible time registers do not follow the counters.
- R4: The counters keep advancing while frozen. After freeze is cleared without any time writes, the next tick shows a time that includes every elapsed tick.
- R5: A refresh already scheduled by a tick in the previous cycle still completes when freeze is set in that cycle.
- R6: Time-register writes made while freeze is 1 appear in the user registers at once. They are loaded into the counters by the control write that clears freeze. Time-register writes made while freeze is 0 are ignored.
- R7: Rollover rules:
  - seconds and minutes wrap 59→00 and hours wrap 23→00;
  - day of week wraps 07→01;
  - month wraps 12→01;
  - year wraps 99→00 and adds one to the century.
- R8: Day of month wraps after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. February wraps after 28, or after 29 when the year is divisible by 4.
- R9: While control bit 2 (run) is 0, ticks do not advance the counters.
- R10: Flags bit 0 is set when the new time at a tick matches all four alarm fields and at least one bit of enables is set. Enables bit 0 is the interrupt enable and bit 1 is the silent enable. With both enable bits 0, a match leaves the flag clear.
- R11: A bus read of the flags register returns the flag and then clears it. `irq` is high exactly while the flag and enables bit 0 are both 1.
- R12: Register map:
  - offsets 0–7 are second, minute, hour, day of month, day of week, month, year and century;
  - offsets 8–11 are alarm second, minute, hour and day of month;
  - offset 12 is enables, offset 13 is flags, offset 14 is control (bit 0 is the stored 24-hour mode bit);
  - offset 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_cs | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| irq | output | 1 | Alarm interrupt |

## Verification
Plain ticks from the reset time show the basic advance and the one-cycle refresh lag. A near-overflow time committed through the freeze path ripples a carry through every field up to the century. Ticks issued while frozen, while stopped, and in the exact cycle that freeze is set separate four behaviours: a clock that runs behind a frozen copy, a clock that stops, a refresh that lets an already-scheduled copy finish, and one that wrongly drops it. Alarm runs with the interrupt enable, the silent enable only, and neither enable separate the flag condition from the interrupt gating. The February cases for a leap and a non-leap year, plus a 30-day month, exercise the month-length logic.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 8;
  localparam int NALARM = 4;

  typedef enum logic [2:0] {
    F_SEC, F_MIN, F_HOUR, F_MDAY, F_WDAY, F_MON, F_YEAR, F_CENT
  } field_e;

  typedef logic [7:0] bcd_t;
  typedef logic [NFIELD-1:0][7:0] tvec_t;

  // century, year, month, wday, mday, hour, min, sec
  localparam tvec_t TIME_RESET = {8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input bcd_t yr);
    logic lo0, lo2;
    lo0 = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    lo2 = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return yr[4] ? lo2 : lo0;
  endfunction

  function automatic bcd_t month_len(input bcd_t mon, input bcd_t yr);
    case (mon)
      8'h02: return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic all_bcd(input tvec_t t);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NFIELD; i++)
      ok = ok && (t[i][3:0] <= 4'd9) && (t[i][7:4] <= 4'd9);
    return ok;
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  load,
  input  tvec_t ld_val,
  output tvec_t cnt,
  output tvec_t nxt
);
  always_comb begin
    nxt = cnt;
    if (cnt[F_SEC] != 8'h59) nxt[F_SEC] = bcd_inc(cnt[F_SEC]);
    else begin
      nxt[F_SEC] = 8'h00;
      if (cnt[F_MIN] != 8'h59) nxt[F_MIN] = bcd_inc(cnt[F_MIN]);
      else begin
        nxt[F_MIN] = 8'h00;
        if (cnt[F_HOUR] != 8'h23) nxt[F_HOUR] = bcd_inc(cnt[F_HOUR]);
        else begin
          nxt[F_HOUR] = 8'h00;
          nxt[F_WDAY] = (cnt[F_WDAY] >= 8'h07) ? 8'h01 : bcd_inc(cnt[F_WDAY]);
          if (cnt[F_MDAY] < month_len(cnt[F_MON], cnt[F_YEAR]))
            nxt[F_MDAY] = bcd_inc(cnt[F_MDAY]);
          else begin
            nxt[F_MDAY] = 8'h01;
            if (cnt[F_MON] < 8'h12) nxt[F_MON] = bcd_inc(cnt[F_MON]);
            else begin
              nxt[F_MON] = 8'h01;
              if (cnt[F_YEAR] != 8'h99) nxt[F_YEAR] = bcd_inc(cnt[F_YEAR]);
              else begin
                nxt[F_YEAR] = 8'h00;
                nxt[F_CENT] = bcd_inc(cnt[F_CENT]);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= TIME_RESET;
    else if (load) cnt <= ld_val;
    else if (adv)  cnt <= nxt;
  end

  AST_COUNTER_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    all_bcd(cnt)); // R1
  AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(ld_val))); // R6
endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       copy_en,
  input  tvec_t      cnt,
  input  logic       freeze,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic       dirty_clr,
  output tvec_t      user,
  output logic       dirty
);
  logic wr_ok;
  assign wr_ok = wr_en && freeze;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)                          user[i] <= TIME_RESET[i];
      else if (wr_ok && (wr_idx == 3'(i))) user[i] <= wr_data;
      else if (copy_en)                    user[i] <= cnt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         dirty <= 1'b0;
    else if (wr_ok)     dirty <= 1'b1;
    else if (dirty_clr) dirty <= 1'b0;
  end

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !copy_en && !wr_en) |=> $stable(user)); // R3
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic       tick_adv,
  input  tvec_t      nxt,
  input  logic       flag_rd,
  output logic [NALARM-1:0][7:0] alm,
  output logic [1:0] en,
  output logic       flag,
  output logic       irq
);
  logic match, set;

  for (genvar i = 0; i < NALARM; i++) begin : g_alm
    always_ff @(posedge clk) begin
      if (!rst_n)                              alm[i] <= 8'h00;
      else if (wr_en && (wr_idx == 3'(i)))     alm[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  en <= 2'b00;
    else if (wr_en && (wr_idx == 3'(NALARM)))    en <= wr_data[1:0];
  end

  assign match = (nxt[F_SEC] == alm[0]) && (nxt[F_MIN] == alm[1]) &&
                 (nxt[F_HOUR] == alm[2]) && (nxt[F_MDAY] == alm[3]);
  assign set = tick_adv && match && (|en);

  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set)     flag <= 1'b1;
    else if (flag_rd) flag <= 1'b0;
  end

  assign irq = flag && en[0];

  AST_FLAG_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !set) |=> !flag); // R11
  AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(en) != 2'b00)); // R10
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_ALM0 = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_FLG  = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(14);
  localparam int B_H24 = 0, B_RUN = 2, B_FRZ = 3;

  logic ctl_h24, ctl_run, ctl_frz;
  logic time_wr, alm_wr, ctl_wr, flag_rd, commit, tick_adv, copy_pend, dirty;
  tvec_t cnt, nxt, user;
  logic [NALARM-1:0][7:0] alm;
  logic [1:0] en;
  logic flag;

  assign time_wr = bus_cs && bus_we && (bus_addr < A_ALM0);
  assign alm_wr  = bus_cs && bus_we && (bus_addr >= A_ALM0) && (bus_addr <= A_EN);
  assign ctl_wr  = bus_cs && bus_we && (bus_addr == A_CTL);
  assign flag_rd = bus_cs && !bus_we && (bus_addr == A_FLG);
  assign commit  = ctl_wr && ctl_frz && !bus_wdata[B_FRZ] && dirty;
  assign tick_adv = sec_tick && ctl_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_h24 <= 1'b1;
      ctl_run <= 1'b1;
      ctl_frz <= 1'b0;
    end else if (ctl_wr) begin
      ctl_h24 <= bus_wdata[B_H24];
      ctl_run <= bus_wdata[B_RUN];
      ctl_frz <= bus_wdata[B_FRZ];
    end
  end

  // refresh is scheduled from the freeze state at the tick edge
  always_ff @(posedge clk) begin
    if (!rst_n) copy_pend <= 1'b0;
    else        copy_pend <= tick_adv && !commit && !ctl_frz;
  end

  rtc_time_chain u_chain (
    .clk(clk), .rst_n(rst_n), .adv(tick_adv), .load(commit),
    .ld_val(user), .cnt(cnt), .nxt(nxt)
  );

  rtc_user_regs u_user (
    .clk(clk), .rst_n(rst_n), .copy_en(copy_pend), .cnt(cnt),
    .freeze(ctl_frz), .wr_en(time_wr), .wr_idx(bus_addr[2:0]),
    .wr_data(bus_wdata), .dirty_clr(commit), .user(user), .dirty(dirty)
  );

  rtc_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .wr_en(alm_wr), .wr_idx(3'(bus_addr - A_ALM0)),
    .wr_data(bus_wdata), .tick_adv(tick_adv && !commit), .nxt(nxt),
    .flag_rd(flag_rd), .alm(alm), .en(en), .flag(flag), .irq(irq)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr < A_ALM0)                         bus_rdata = user[bus_addr[2:0]];
    else if (bus_addr < A_EN)                      bus_rdata = alm[bus_addr[1:0]];
    else if (bus_addr == A_EN)                     bus_rdata = {6'd0, en};
    else if (bus_addr == A_FLG)                    bus_rdata = {7'd0, flag};
    else if (bus_addr == A_CTL)
      bus_rdata = {4'd0, ctl_frz, ctl_run, 1'b0, ctl_h24};
  end

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_run && !commit) |=> $stable(cnt)); // R9
  AST_REFRESH_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_pend && !time_wr) |=> (user == $past(cnt))); // R2
endmodule

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;
  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0;
  logic bus_cs = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  logic irq;
  int nchk = 0, nfail = 0;

  typedef struct { logic [3:0] a; logic [7:0] d; string tag; } exp_t;
  exp_t q[$];

  localparam logic [3:0] SEC = 0, MIN = 1, HOUR = 2, MDAY = 3, WDAY = 4,
    MON = 5, YEAR = 6, CENT = 7, AL_SEC = 8, AL_MIN = 9, AL_HOUR = 10,
    AL_MDAY = 11, EN = 12, FLG = 13, CTL = 14;

  always #2.5 clk = ~clk;

  bcd_rtc #(.ADDR_W(4)) u0 (.*);

  // monitor: pops expected read data as reads appear on the bus
  always @(negedge clk) begin
    if (rst_n && bus_cs && !bus_we) begin
      exp_t e;
      if (q.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL scoreboard empty at addr %0d", bus_addr);
      end else begin
        e = q.pop_front();
        nchk++;
        if (bus_rdata !== e.d || bus_addr !== e.a) begin
          nfail++;
          $display("FAIL %s addr %0d: actual %h expected %h", e.tag, e.a, bus_rdata, e.d);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1; bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1; bus_cs = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1; bus_cs = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; sec_tick = 1;
    @(posedge clk); #1; sec_tick = 0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    nchk++;
    if (irq !== exp) begin
      nfail++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] c, y, mo, md, wd, h, mi, s);
    wr(CTL, 8'h0D);
    wr(SEC, s); wr(MIN, mi); wr(HOUR, h); wr(MDAY, md);
    wr(WDAY, wd); wr(MON, mo); wr(YEAR, y); wr(CENT, c);
    wr(CTL, 8'h05);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1 R12 reset state and map
    rd(SEC, 8'h00, "R1 sec"); rd(MDAY, 8'h01, "R1 mday"); rd(WDAY, 8'h01, "R1 wday");
    rd(CENT, 8'h20, "R1 cent"); rd(CTL, 8'h05, "R1 ctl"); rd(4'd15, 8'h00, "R12 unused");
    rd(FLG, 8'h00, "R12 flags");
    // R2 basic advance
    tick(); rd(SEC, 8'h01, "R2 advance");
    // R6 write ignored when not frozen
    wr(SEC, 8'h33); rd(SEC, 8'h01, "R6 ignored write");
    tick(); rd(SEC, 8'h02, "R6 counter untouched");
    // R6 commit then R7 full rollover
    wr(CTL, 8'h0D);
    wr(SEC, 8'h58); wr(MIN, 8'h59); wr(HOUR, 8'h23); wr(MDAY, 8'h31);
    wr(WDAY, 8'h07); wr(MON, 8'h12); wr(YEAR, 8'h99); wr(CENT, 8'h20);
    rd(SEC, 8'h58, "R6 frozen write visible");
    wr(CTL, 8'h05);
    tick(); rd(SEC, 8'h59, "R6 commit");
    tick();
    rd(SEC, 8'h00, "R7 sec"); rd(MIN, 8'h00, "R7 min"); rd(HOUR, 8'h00, "R7 hour");
    rd(MDAY, 8'h01, "R7 mday"); rd(WDAY, 8'h01, "R7 wday"); rd(MON, 8'h01, "R7 mon");
    rd(YEAR, 8'h00, "R7 year"); rd(CENT, 8'h21, "R7 cent");
    // R3 R4 freeze keeps counting
    wr(CTL, 8'h0D); tick(); tick(); tick();
    rd(SEC, 8'h00, "R3 frozen");
    wr(CTL, 8'h05); rd(SEC, 8'h00, "R4 no commit without writes");
    tick(); rd(SEC, 8'h04, "R4 counted while frozen");
    // R5 freeze in the cycle after a tick
    @(posedge clk); #1 sec_tick = 1;
    @(posedge clk); #1 sec_tick = 0; bus_cs = 1; bus_we = 1; bus_addr = CTL; bus_wdata = 8'h0D;
    @(posedge clk); #1 bus_cs = 0; bus_we = 0;
    rd(SEC, 8'h05, "R5 refresh completes");
    tick(); rd(SEC, 8'h05, "R3 frozen after");
    wr(CTL, 8'h05); tick(); rd(SEC, 8'h07, "R4 resumed");
    // R9 stop
    wr(CTL, 8'h01); tick(); tick(); rd(CTL, 8'h01, "R12 ctl readback");
    wr(CTL, 8'h05); tick(); rd(SEC, 8'h08, "R9 stopped");
    // R8 month lengths
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); tick();
    rd(MDAY, 8'h01, "R8 feb nonleap mday"); rd(MON, 8'h03, "R8 feb nonleap mon");
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); tick();
    rd(MDAY, 8'h29, "R8 feb leap mday"); rd(MON, 8'h02, "R8 feb leap mon");
    set_time(8'h20, 8'h24, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59); tick();
    rd(MDAY, 8'h01, "R8 apr mday"); rd(MON, 8'h05, "R8 apr mon");
    // R10 R11 alarm with interrupt enable
    set_time(8'h20, 8'h24, 8'h05, 8'h01, 8'h04, 8'h10, 8'h20, 8'h29);
    wr(AL_SEC, 8'h30); wr(AL_MIN, 8'h20); wr(AL_HOUR, 8'h10); wr(AL_MDAY, 8'h01);
    wr(EN, 8'h01);
    chk_irq(1'b0, "R11 idle");
    tick(); chk_irq(1'b1, "R11 irq on match");
    rd(FLG, 8'h01, "R10 flag set"); rd(FLG, 8'h00, "R11 read clears");
    chk_irq(1'b0, "R11 irq cleared");
    // R10 no enables
    set_time(8'h20, 8'h24, 8'h05, 8'h01, 8'h04, 8'h10, 8'h20, 8'h29);
    wr(EN, 8'h00); tick(); rd(FLG, 8'h00, "R10 disabled");
    // R10 R11 silent enable only
    set_time(8'h20, 8'h24, 8'h05, 8'h01, 8'h04, 8'h10, 8'h20, 8'h29);
    wr(EN, 8'h02); tick(); chk_irq(1'b0, "R11 silent no irq");
    rd(FLG, 8'h01, "R10 silent flag"); rd(EN, 8'h02, "R12 enables");
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule